// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind an I2C bit-level receiver and decides, from the bytes the receiver has already assembled, whether the local slave is being addressed. Each incoming byte comes with a strobe and a marker that flags the first byte after a START condition. START and STOP are also reported as single-cycle strobes. The block compares those bytes against a configured own address, in either 7-bit or 10-bit form. It can also recognise the general call address when that is enabled.

A successful comparison produces a one-cycle match pulse. It also sets a held "addressed" level, which is the permission for the data phase that follows. The transfer direction and a general-call flag are latched with the match and stay valid until the next START or STOP. In 10-bit mode the block follows the two-byte header scheme. After a completed 10-bit write addressing, a repeated START with a read header re-addresses the slave without a second address byte.

Top module: `i2c_addr_match`

## Requirements
- R1: With addr_ext=0, a first byte whose bits 7:1 equal own_addr (non-zero) raises match_pulse for exactly the one cycle after the byte strobe, sets addressed, and latches bit 0 of that byte into rw_dir (1 = read).
- R2: With addr_ext=0, the value of addr_hi has no effect on matching.
- R3: With addr_ext=1, the 7-bit comparison is off. A first byte equal to 5'b11110, addr_hi[2:1], 0 arms the matcher, and no pulse is given for it. If the next byte equals {addr_hi[0], own_addr}, match_pulse rises one cycle later with rw_dir=0. Any other second byte gives no match.
- R4: After a completed 10-bit match with no STOP since, a first byte equal to 5'b11110, addr_hi[2:1], 1 matches at once with rw_dir=1. Without such a prior match, that byte does not match.
- R5: The byte 0x00 as a first byte matches only when gc_en=1. It then sets gc_flag with rw_dir=0. With gc_en=0 it never matches, not even when own_addr is 0. The byte 0x01 never produces a general-call match.
- R6: addressed, gc_flag and rw_dir hold until the next START or STOP. Bytes that are neither first bytes nor an expected 10-bit second byte produce no match pulse.
- R7: START or STOP clears addressed, gc_flag, rw_dir and any armed 10-bit header. STOP also forgets a prior 10-bit match.
- R8: A synchronous reset clears all outputs and all internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Assembled byte strobe |
| byte_data | input | 8 | Assembled byte, MSB first on the bus |
| byte_first | input | 1 | Byte is the first after a START |
| bus_start | input | 1 | START or repeated START seen |
| bus_stop | input | 1 | STOP seen |
| own_addr | input | 7 | Own address, or low seven bits in 10-bit mode |
| addr_ext | input | 1 | 0 = 7-bit, 1 = 10-bit addressing |
| addr_hi | input | 3 | Address bits 9:7 in 10-bit mode |
| gc_en | input | 1 | General call recognition enable |
| match_pulse | output | 1 | One-cycle address match |
| gc_flag | output | 1 | Current addressing was a general call |
| rw_dir | output | 1 | Latched direction, 1 = read |
| addressed | output | 1 | Data phase permitted |

## Verification
The bench builds the block with its default widths: a 7-bit own address and a 3-bit upper field. These give 8-bit bytes, 10-bit addresses and the 11110 header tag, so both addressing schemes, the header-only read re-match and the general call code are all reachable. The own address 0x3A and upper field 3'b101 make the header, the second byte and the 7-bit byte differ, so a wrong field pick shows up as a missing or extra pulse.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  parameter int ADDR_W_DEF = 7;
  parameter int HI_W_DEF   = 3;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WAIT_LO = 2'd1
  } phase_e;
endpackage

// File: rtl/i2c_am_decode.sv
module i2c_am_decode #(
  parameter int AW = 7,
  parameter int HW = 3
) (
  input  logic [AW:0]   byte_i,
  input  logic [AW-1:0] own_i,
  input  logic [HW-1:0] hi_i,
  output logic          hit_own,
  output logic          hit_gc_code,
  output logic          hit_hdr,
  output logic          hit_lo
);
  localparam int HDR_BITS = AW + 1 - HW;
  localparam int HDR_LSB  = AW - HDR_BITS + 1;
  localparam logic [HDR_BITS-1:0] HDR_TAG = {{(HDR_BITS-1){1'b1}}, 1'b0};

  always_comb begin
    hit_own     = (byte_i[AW:1] == own_i) && (|byte_i[AW:1]);
    hit_gc_code = (byte_i == '0);
    hit_hdr     = (byte_i[AW:HDR_LSB] == HDR_TAG) &&
                  (byte_i[HW-1:1] == hi_i[HW-1:1]);
    hit_lo      = (byte_i == {hi_i[0], own_i});
  end
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic byte_vld,
  input  logic byte_first,
  input  logic rw_bit,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic addr_ext,
  input  logic gc_en,
  input  logic hit_own,
  input  logic hit_gc_code,
  input  logic hit_hdr,
  input  logic hit_lo,
  output logic match_pulse,
  output logic gc_flag,
  output logic rw_dir,
  output logic addressed
);
  phase_e phase_q;
  logic   ten_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      ten_prev_q  <= 1'b0;
      match_pulse <= 1'b0;
      gc_flag     <= 1'b0;
      rw_dir      <= 1'b0;
      addressed   <= 1'b0;
    end else begin
      match_pulse <= 1'b0;
      if (bus_start || bus_stop) begin
        phase_q   <= PH_IDLE;
        gc_flag   <= 1'b0;
        rw_dir    <= 1'b0;
        addressed <= 1'b0;
        if (bus_stop) ten_prev_q <= 1'b0;
      end else if (byte_vld) begin
        if (byte_first) begin
          phase_q <= PH_IDLE;
          if (gc_en && hit_gc_code) begin
            match_pulse <= 1'b1;
            addressed   <= 1'b1;
            gc_flag     <= 1'b1;
            rw_dir      <= 1'b0;
            ten_prev_q  <= 1'b0;
          end else if (!addr_ext) begin
            ten_prev_q <= 1'b0;
            if (hit_own) begin
              match_pulse <= 1'b1;
              addressed   <= 1'b1;
              gc_flag     <= 1'b0;
              rw_dir      <= rw_bit;
            end
          end else if (hit_hdr && !rw_bit) begin
            phase_q <= PH_WAIT_LO;
          end else if (hit_hdr && rw_bit && ten_prev_q) begin
            match_pulse <= 1'b1;
            addressed   <= 1'b1;
            gc_flag     <= 1'b0;
            rw_dir      <= 1'b1;
          end else begin
            ten_prev_q <= 1'b0;
          end
        end else if (phase_q == PH_WAIT_LO) begin
          phase_q <= PH_IDLE;
          if (hit_lo) begin
            match_pulse <= 1'b1;
            addressed   <= 1'b1;
            gc_flag     <= 1'b0;
            rw_dir      <= 1'b0;
            ten_prev_q  <= 1'b1;
          end else begin
            ten_prev_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int HI_W   = HI_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [ADDR_W:0]   byte_data,
  input  logic              byte_first,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              addr_ext,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              gc_en,
  output logic              match_pulse,
  output logic              gc_flag,
  output logic              rw_dir,
  output logic              addressed
);
  logic hit_own, hit_gc_code, hit_hdr, hit_lo;

  i2c_am_decode #(.AW(ADDR_W), .HW(HI_W)) u_dec (
    .byte_i      (byte_data),
    .own_i       (own_addr),
    .hi_i        (addr_hi),
    .hit_own     (hit_own),
    .hit_gc_code (hit_gc_code),
    .hit_hdr     (hit_hdr),
    .hit_lo      (hit_lo)
  );

  i2c_am_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .byte_vld    (byte_vld),
    .byte_first  (byte_first),
    .rw_bit      (byte_data[0]),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .addr_ext    (addr_ext),
    .gc_en       (gc_en),
    .hit_own     (hit_own),
    .hit_gc_code (hit_gc_code),
    .hit_hdr     (hit_hdr),
    .hit_lo      (hit_lo),
    .match_pulse (match_pulse),
    .gc_flag     (gc_flag),
    .rw_dir      (rw_dir),
    .addressed   (addressed)
  );
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic clk,
  input logic rst,
  input logic byte_vld,
  input logic bus_start,
  input logic bus_stop,
  input logic gc_en,
  input logic match_pulse,
  input logic gc_flag,
  input logic rw_dir,
  input logic addressed
);
  AST_PULSE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(byte_vld)) else $error("pulse without byte"); // R1
  AST_GC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (match_pulse && gc_flag) |-> $past(gc_en)) else $error("gc while disabled"); // R5
  AST_GC_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    gc_flag |-> !rw_dir) else $error("gc with read"); // R5
  AST_ADDR_RISE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(addressed) |-> match_pulse) else $error("addressed without match"); // R6
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(bus_stop) |-> (!addressed && !match_pulse && !gc_flag)) else $error("stop kept state"); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(bus_start) |-> (!addressed && !match_pulse)) else $error("start kept state"); // R7
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .byte_vld    (byte_vld),
  .bus_start   (bus_start),
  .bus_stop    (bus_stop),
  .gc_en       (gc_en),
  .match_pulse (match_pulse),
  .gc_flag     (gc_flag),
  .rw_dir      (rw_dir),
  .addressed   (addressed)
);

// File: tb/tb_i2c_addr_match.sv
`timescale 1ns/1ps
module tb_i2c_addr_match;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_first = 1'b0;
  logic bus_start = 1'b0;
  logic bus_stop = 1'b0;
  logic [6:0] own_addr = '0;
  logic addr_ext = 1'b0;
  logic [2:0] addr_hi = '0;
  logic gc_en = 1'b0;
  logic match_pulse, gc_flag, rw_dir, addressed;

  int n_chk = 0;
  int n_bad = 0;
  logic s_match, s_gc, s_rw, s_addr;

  always #2.5 clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_first(byte_first), .bus_start(bus_start), .bus_stop(bus_stop),
    .own_addr(own_addr), .addr_ext(addr_ext), .addr_hi(addr_hi), .gc_en(gc_en),
    .match_pulse(match_pulse), .gc_flag(gc_flag), .rw_dir(rw_dir), .addressed(addressed)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic snap();
    s_match = match_pulse; s_gc = gc_flag; s_rw = rw_dir; s_addr = addressed;
  endtask

  task automatic send(logic [7:0] b, logic first);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = b; byte_first = first;
    @(posedge clk); #1; snap();
    @(negedge clk);
    byte_vld = 1'b0; byte_first = 1'b0;
  endtask

  task automatic cond(logic is_stop);
    @(negedge clk);
    if (is_stop) bus_stop = 1'b1; else bus_start = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0; bus_start = 1'b0;
    snap();
  endtask

  task automatic t_reset();
    snap();
    chk("R8", "match after reset", {7'd0, s_match}, 8'd0);
    chk("R8", "addressed after reset", {5'd0, s_addr, s_gc, s_rw}, 8'd0);
  endtask

  task automatic t_seven();
    own_addr = 7'h3A; addr_ext = 1'b0;
    cond(1'b0); send(8'h74, 1'b1);
    chk("R1", "7b write match", {6'd0, s_match, s_addr}, 8'h03);
    chk("R1", "7b write dir", {7'd0, s_rw}, 8'd0);
    @(posedge clk); #1;
    chk("R1", "pulse one cycle", {7'd0, match_pulse}, 8'd0);
    cond(1'b0); send(8'h75, 1'b1);
    chk("R1", "7b read match/dir", {6'd0, s_match, s_rw}, 8'h03);
    cond(1'b0); send(8'h76, 1'b1);
    chk("R1", "7b mismatch", {6'd0, s_match, s_addr}, 8'd0);
    addr_hi = 3'b111;
    cond(1'b0); send(8'h74, 1'b1);
    chk("R2", "hi ignored in 7b", {7'd0, s_match}, 8'd1);
    addr_hi = 3'b000;
  endtask

  task automatic t_hold();
    cond(1'b0); send(8'h75, 1'b1);
    send(8'h74, 1'b0);
    chk("R6", "data byte no pulse", {7'd0, s_match}, 8'd0);
    chk("R6", "state held", {6'd0, s_addr, s_rw}, 8'h03);
    cond(1'b1);
    chk("R7", "stop clears", {6'd0, s_addr, s_rw}, 8'd0);
  endtask

  task automatic t_gc();
    own_addr = 7'h00; addr_ext = 1'b0; gc_en = 1'b0;
    cond(1'b0); send(8'h00, 1'b1);
    chk("R5", "gc disabled", {6'd0, s_match, s_gc}, 8'd0);
    gc_en = 1'b1;
    cond(1'b0); send(8'h00, 1'b1);
    chk("R5", "gc enabled", {5'd0, s_match, s_gc, s_rw}, 8'h06);
    cond(1'b0);
    chk("R7", "start clears gc", {6'd0, s_gc, s_addr}, 8'd0);
    send(8'h01, 1'b1);
    chk("R5", "0x01 no gc", {6'd0, s_match, s_gc}, 8'd0);
    gc_en = 1'b0; own_addr = 7'h3A;
    cond(1'b1);
  endtask

  task automatic t_ten();
    addr_ext = 1'b1; addr_hi = 3'b101; own_addr = 7'h3A;
    cond(1'b0); send(8'h74, 1'b1);
    chk("R3", "7b off in 10b", {7'd0, s_match}, 8'd0);
    cond(1'b0); send(8'hF4, 1'b1);
    chk("R3", "header alone", {6'd0, s_match, s_addr}, 8'd0);
    send(8'h3A, 1'b0);
    chk("R3", "wrong low byte", {7'd0, s_match}, 8'd0);
    cond(1'b0); send(8'hF5, 1'b1);
    chk("R4", "read hdr w/o prior", {7'd0, s_match}, 8'd0);
    cond(1'b0); send(8'hF2, 1'b1); send(8'hBA, 1'b0);
    chk("R3", "wrong hi bits", {7'd0, s_match}, 8'd0);
    cond(1'b0); send(8'hF4, 1'b1); cond(1'b0); send(8'hBA, 1'b0);
    chk("R7", "start drops armed hdr", {7'd0, s_match}, 8'd0);
    cond(1'b0); send(8'hF4, 1'b1); send(8'hBA, 1'b0);
    chk("R3", "10b write match", {5'd0, s_match, s_addr, s_rw}, 8'h06);
    cond(1'b0); send(8'hF5, 1'b1);
    chk("R4", "rep start read", {5'd0, s_match, s_addr, s_rw}, 8'h07);
    cond(1'b1); cond(1'b0); send(8'hF5, 1'b1);
    chk("R7", "stop forgets prior", {7'd0, s_match}, 8'd0);
    cond(1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_seven();
    t_hold();
    t_gc();
    t_ten();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule